// File: doc/BRIEF.md
# Commutation-Preloaded Channel Output Control

This block keeps the output configuration of a set of timer channels: for each channel an output-enable bit, a complementary-output-enable bit and an output-mode code. Software writes one channel's whole field at a time through a simple write port. Channels that drive a complementary output pair can run in preload mode. In that mode a write lands only in a shadow copy, and all preloaded channels move their shadow into the active copy together, in one clock, when a commutation event occurs. This lets the drive pattern of a multi-phase output stage switch at once, with no half-updated pattern in between.

A commutation event is a one-clock software strobe. When the source-select input is set, a rising edge on the trigger input is also an event. Each event sets a sticky flag, which software clears by a one-clock clear pulse. Two small state machines run the control. The trigger tracker has the states TRIG_LO and TRIG_HI. It moves TRIG_LO to TRIG_HI when the trigger input is 1, and reports a rise on that transition. It moves TRIG_HI to TRIG_LO when the input is 0. The flag machine has the states FLAG_CLEAR and FLAG_SET. It moves FLAG_CLEAR to FLAG_SET on any event. It moves FLAG_SET to FLAG_CLEAR on a clear pulse in a cycle with no event.

Top module: `cmt_outctl`

## Requirements
- R1: After reset every channel's active field is zero (all outputs disabled, mode 0), the shadow copies are zero, the flag is 0, and the trigger tracker treats the previous trigger sample as 0.
- R2: With preload_en at 0, a write to any channel appears on that channel's active outputs after the next rising clock edge. The field is {oe, noe, mode[MODE_W-1:0]}, with oe as the most significant bit.
- R3: With preload_en at 1, a write to a channel with index below NUM_COMP changes only its shadow copy. The active outputs of that channel stay unchanged until a commutation event.
- R4: With com_src_sel at 0, only sw_com makes a commutation event. A trigger rising edge changes neither the active fields nor the flag.
- R5: With com_src_sel at 1, sw_com or a trigger rising edge makes an event. A rising edge is trig_in at 1 at a clock edge after it was 0 at the previous edge. A trigger held high makes no further events.
- R6: Channels with index NUM_COMP or above have no preload. A write to one of them takes effect after the next edge whatever preload_en is.
- R7: If a write to a preloaded channel and an event fall in the same cycle, the active copy takes the shadow value from before the write. The shadow then holds the newly written value, and the next event moves it across.
- R8: Every event sets com_flag on the next edge. flag_clr clears it. When an event and flag_clr coincide, the flag stays set.
- R9: One event moves the shadow of every preloaded channel into its active copy in the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one channel field |
| wr_chan | input | CH_IDX_W | Channel index of the write |
| wr_oe | input | 1 | Output-enable bit to write |
| wr_noe | input | 1 | Complementary-output-enable bit to write |
| wr_mode | input | MODE_W | Output-mode code to write |
| preload_en | input | 1 | 1: preloaded channels write their shadow only |
| com_src_sel | input | 1 | 1: trigger rising edges also commutate |
| sw_com | input | 1 | One-clock software commutation strobe |
| trig_in | input | 1 | Trigger input, synchronous to clk |
| flag_clr | input | 1 | One-clock clear of the commutation flag |
| act_oe | output | NUM_CH | Active output-enable bits |
| act_noe | output | NUM_CH | Active complementary-output-enable bits |
| act_mode | output | NUM_CH*MODE_W | Active mode codes, channel c at bits c*MODE_W upward |
| com_flag | output | 1 | Sticky commutation-event flag |

## Verification
The hardest case to reach is a write and a commutation event in the same cycle, when the shadow already holds a pending value that differs from both the active value and the new write. Only then does the result show whether the active copy took the old shadow or the new data. The stimulus first parks a distinct value in the shadow, then issues a second write together with the software strobe. A further strobe then shows that the second value survived in the shadow. Getting a single event from a trigger that stays high needs a similar sequence: the trigger is left high across the change of the source select, so that no edge is seen until it drops and rises again.

// File: rtl/cmt_outctl_pkg.sv
package cmt_outctl_pkg;

    // Number of enable bits that precede the mode code in a channel field.
    localparam int unsigned ENABLE_BITS = 2;

    typedef enum logic {
        TRIG_LO = 1'b0,
        TRIG_HI = 1'b1
    } trig_state_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

endpackage

// File: rtl/cmt_trig_track.sv
module cmt_trig_track
    import cmt_outctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);

    trig_state_e state_q;
    trig_state_e state_d;

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            TRIG_LO: state_d = trig_in ? TRIG_HI : TRIG_LO;
            TRIG_HI: state_d = trig_in ? TRIG_HI : TRIG_LO;
            default: state_d = TRIG_LO;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRIG_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: a rise is the LO -> HI transition.
    always_comb begin
        unique case (state_q)
            TRIG_LO: trig_rise = trig_in;
            TRIG_HI: trig_rise = 1'b0;
            default: trig_rise = 1'b0;
        endcase
    end

    // R5: a level held high never produces two rises in a row.
    a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);

endmodule

// File: rtl/cmt_com_source.sv
module cmt_com_source
    import cmt_outctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_com,
    input  logic com_src_sel,
    input  logic trig_rise,
    input  logic flag_clr,
    output logic com_evt,
    output logic com_flag
);

    flag_state_e flag_q;
    flag_state_e flag_d;

    // Event source selection.
    always_comb begin
        com_evt = sw_com | (com_src_sel & trig_rise);
    end

    // Next-state logic: a new event outranks a clear.
    always_comb begin
        unique case (flag_q)
            FLAG_CLEAR: flag_d = com_evt ? FLAG_SET : FLAG_CLEAR;
            FLAG_SET:   flag_d = (flag_clr && !com_evt) ? FLAG_CLEAR : FLAG_SET;
            default:    flag_d = FLAG_CLEAR;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= FLAG_CLEAR;
        end else begin
            flag_q <= flag_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (flag_q)
            FLAG_CLEAR: com_flag = 1'b0;
            FLAG_SET:   com_flag = 1'b1;
            default:    com_flag = 1'b0;
        endcase
    end

    // R8: any event leaves the flag set on the next cycle.
    a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        com_evt |=> com_flag);

    // R4: without a strobe and without trigger selection the flag cannot move.
    a_r4_no_trig_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_com && !com_src_sel && !flag_clr) |=> $stable(com_flag));

endmodule

// File: rtl/cmt_chan_slot.sv
module cmt_chan_slot
    import cmt_outctl_pkg::*;
#(
    parameter int unsigned MODE_W   = 3,
    parameter bit          HAS_COMP = 1'b1,
    localparam int unsigned FLD_W   = ENABLE_BITS + MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [FLD_W-1:0] wr_fld,
    input  logic             preload_en,
    input  logic             com_evt,
    output logic [FLD_W-1:0] act_fld
);

    logic [FLD_W-1:0] shadow_q;
    logic [FLD_W-1:0] act_q;
    logic             use_preload;

    // Preload applies only to slots that drive a complementary pair.
    always_comb begin
        use_preload = HAS_COMP && preload_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_hit) begin
                shadow_q <= wr_fld;
            end
            if (use_preload) begin
                // Event copies the shadow as it was before any write this cycle.
                if (com_evt) begin
                    act_q <= shadow_q;
                end
            end else if (wr_hit) begin
                act_q <= wr_fld;
            end else if (HAS_COMP && com_evt) begin
                act_q <= shadow_q;
            end
        end
    end

    assign act_fld = act_q;

    generate
        if (HAS_COMP) begin : g_comp_checks
            // R3: a preloaded slot holds its active value until an event.
            a_r3_hold_until_com: assert property (@(posedge clk) disable iff (!rst_n)
                (preload_en && !com_evt) |=> $stable(act_fld));

            // R2: without preload the write reaches the outputs next cycle.
            a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
                (!preload_en && wr_hit) |=> (act_fld == $past(wr_fld)));

            // R7: collision of a write and an event.
            a_r7_collision: assert property (@(posedge clk) disable iff (!rst_n)
                (preload_en && wr_hit && com_evt) |=>
                    ((act_fld == $past(shadow_q)) && (shadow_q == $past(wr_fld))));
        end else begin : g_plain_checks
            // R6: plain slots follow writes directly.
            a_r6_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit |=> (act_fld == $past(wr_fld)));

            // R6: plain slots ignore events.
            a_r6_plain_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_hit |=> $stable(act_fld));
        end
    endgenerate

endmodule

// File: rtl/cmt_outctl.sv
module cmt_outctl
    import cmt_outctl_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned NUM_COMP = 2,
    parameter int unsigned MODE_W   = 3,
    localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned FLD_W    = ENABLE_BITS + MODE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CH_IDX_W-1:0]        wr_chan,
    input  logic                       wr_oe,
    input  logic                       wr_noe,
    input  logic [MODE_W-1:0]          wr_mode,
    input  logic                       preload_en,
    input  logic                       com_src_sel,
    input  logic                       sw_com,
    input  logic                       trig_in,
    input  logic                       flag_clr,
    output logic [NUM_CH-1:0]          act_oe,
    output logic [NUM_CH-1:0]          act_noe,
    output logic [NUM_CH*MODE_W-1:0]   act_mode,
    output logic                       com_flag
);

    logic             trig_rise;
    logic             com_evt;
    logic [FLD_W-1:0] wr_fld;

    assign wr_fld = {wr_oe, wr_noe, wr_mode};

    cmt_trig_track u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    cmt_com_source u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_com      (sw_com),
        .com_src_sel (com_src_sel),
        .trig_rise   (trig_rise),
        .flag_clr    (flag_clr),
        .com_evt     (com_evt),
        .com_flag    (com_flag)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic             hit;
            logic [FLD_W-1:0] fld;

            assign hit = wr_en && (wr_chan == CH_IDX_W'(ch));

            cmt_chan_slot #(
                .MODE_W   (MODE_W),
                .HAS_COMP (ch < NUM_COMP)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_hit     (hit),
                .wr_fld     (wr_fld),
                .preload_en (preload_en),
                .com_evt    (com_evt),
                .act_fld    (fld)
            );

            assign act_oe[ch]                   = fld[FLD_W-1];
            assign act_noe[ch]                  = fld[FLD_W-2];
            assign act_mode[ch*MODE_W +: MODE_W] = fld[MODE_W-1:0];
        end
    endgenerate

    // R9: one event, with preload on, moves every preloaded slot in one edge:
    // no preloaded active bit can change except on an event cycle.
    a_r9_atomic_move: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !com_evt) |=> ($stable(act_oe[NUM_COMP-1:0]) &&
                                      $stable(act_noe[NUM_COMP-1:0])));

endmodule

// File: tb/cmt_outctl_test.sv
`timescale 1ns/1ps
module cmt_outctl_test;

    localparam int NV = 17;

    // {wr, chan[1:0], fld[4:0], pre, src, sw, trig, clr, xchan[1:0], xfld[4:0], xflag}
    // fld = {oe, noe, mode[2:0]}
    localparam logic [20:0] VECS [NV] = '{
        {1'b1, 2'd0, 5'b10101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 5'b10101, 1'b0}, // 0  R2
        {1'b1, 2'd2, 5'b01010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 5'b01010, 1'b0}, // 1  R6
        {1'b1, 2'd1, 5'b11011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 5'b00000, 1'b0}, // 2  R3
        {1'b1, 2'd0, 5'b01100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 5'b10101, 1'b0}, // 3  R3
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 5'b10101, 1'b0}, // 4  R4
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 5'b01100, 1'b1}, // 5  R9
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 5'b11011, 1'b1}, // 6  R9
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 5'b11011, 1'b0}, // 7  R8
        {1'b1, 2'd1, 5'b00111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 5'b11011, 1'b0}, // 8  R5
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 5'b11011, 1'b0}, // 9  R5
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 5'b00111, 1'b1}, // 10 R5
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 5'b00111, 1'b1}, // 11 R8
        {1'b1, 2'd0, 5'b10001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 5'b01100, 1'b0}, // 12 R3
        {1'b1, 2'd0, 5'b11111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 5'b10001, 1'b1}, // 13 R7
        {1'b0, 2'd0, 5'b00000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 5'b11111, 1'b1}, // 14 R7
        {1'b1, 2'd3, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 5'b00001, 1'b1}, // 15 R6
        {1'b1, 2'd1, 5'b10100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 5'b10100, 1'b1}  // 16 R2
    };

    function automatic string vec_req(input int idx);
        case (idx)
            0, 16:      vec_req = "R2";
            2, 3, 12:   vec_req = "R3";
            4:          vec_req = "R4";
            8, 9, 10:   vec_req = "R5";
            1, 15:      vec_req = "R6";
            13, 14:     vec_req = "R7";
            7, 11:      vec_req = "R8";
            default:    vec_req = "R9";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_chan = '0;
    logic       wr_oe = 1'b0;
    logic       wr_noe = 1'b0;
    logic [2:0] wr_mode = '0;
    logic       preload_en = 1'b0;
    logic       com_src_sel = 1'b0;
    logic       sw_com = 1'b0;
    logic       trig_in = 1'b0;
    logic       flag_clr = 1'b0;
    logic [3:0]  act_oe;
    logic [3:0]  act_noe;
    logic [11:0] act_mode;
    logic        com_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    cmt_outctl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_chan     (wr_chan),
        .wr_oe       (wr_oe),
        .wr_noe      (wr_noe),
        .wr_mode     (wr_mode),
        .preload_en  (preload_en),
        .com_src_sel (com_src_sel),
        .sw_com      (sw_com),
        .trig_in     (trig_in),
        .flag_clr    (flag_clr),
        .act_oe      (act_oe),
        .act_noe     (act_noe),
        .act_mode    (act_mode),
        .com_flag    (com_flag)
    );

    function automatic logic [4:0] chan_fld(input logic [1:0] c);
        chan_fld = {act_oe[c], act_noe[c], act_mode[c*3 +: 3]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [4:0] got, input logic [4:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic check_all_zero(input string tag);
        for (int c = 0; c < 4; c++) begin
            check("R1", $sformatf("%s channel %0d", tag, c), chan_fld(2'(c)), 5'b0);
        end
        check("R1", {tag, " flag"}, {4'b0, com_flag}, 5'b0);
    endtask

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all_zero("in reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en       = VECS[i][20];
            wr_chan     = VECS[i][19:18];
            {wr_oe, wr_noe, wr_mode} = VECS[i][17:13];
            preload_en  = VECS[i][12];
            com_src_sel = VECS[i][11];
            sw_com      = VECS[i][10];
            trig_in     = VECS[i][9];
            flag_clr    = VECS[i][8];
            @(posedge clk);
            #1;
            check(vec_req(i), $sformatf("vector %0d channel %0d", i, VECS[i][7:6]),
                  chan_fld(VECS[i][7:6]), VECS[i][5:1]);
            check(vec_req(i), $sformatf("vector %0d flag", i),
                  {4'b0, com_flag}, {4'b0, VECS[i][0]});
        end

        // R4: repeated trigger rises with source select 0 leave state alone.
        @(negedge clk);
        wr_en = 1'b0; sw_com = 1'b0; flag_clr = 1'b1; preload_en = 1'b1;
        com_src_sel = 1'b0; trig_in = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0;
        wr_en = 1'b1; wr_chan = 2'd0; {wr_oe, wr_noe, wr_mode} = 5'b00110;
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            trig_in = 1'b1;
            @(negedge clk);
            trig_in = 1'b0;
            @(negedge clk);
        end
        check("R4", "channel 0 after ignored rises", chan_fld(2'd0), 5'b11111);
        check("R4", "flag after ignored rises", {4'b0, com_flag}, 5'b0);

        // R1: reset in mid-run clears everything.
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_all_zero("after reset");
        @(negedge clk);
        rst_n = 1'b1;
        preload_en = 1'b1;
        sw_com = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "shadow of channel 0 cleared", chan_fld(2'd0), 5'b0);
        @(negedge clk);
        sw_com = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule